// File: doc/BRIEF.md
# SMBus Byte-Access Memory Slave with Protected Half

This block is an SMBus slave that exposes 256 bytes of storage behind a single 7-bit device address. The storage is split into two 128-byte halves. The lower half is an information ROM whose contents are fixed when the design is elaborated and cannot be changed from the bus. The upper half is a scratch area that the host may read and write.

The host uses two transaction types. A Write Byte sends a command byte and a data byte. A Read Byte sends a command byte, a repeated Start and the read address, and then clocks one byte out of the slave. Bit 7 of the command byte selects the half, and bits 6..0 give the offset within it.

Every stored scratch write starts a self-timed programming interval. During that interval the slave refuses its own address, so the host sees the device as busy. The slave samples SCL and SDA with a synchronizer. It pulls SDA low only through an open-drain output enable.

Top module: `smb_split_mem`

## Requirements
- R1: A Write Byte with command bit 7 = 1 gets an ACK for the address, command and data bytes. It stores the data byte at scratch offset command[6:0], and a later Read Byte of that command returns that byte.
- R2: A Write Byte with command bit 7 = 0 gets an ACK for all three bytes. The data is discarded: a later read returns the unchanged ROM byte, and no busy interval starts, so the next address is ACKed at once.
- R3: A Read Byte returns the selected byte MSB first. ROM byte i (i = 0..127) equals (29*i + ROM_SEED) mod 256, with ROM_SEED = 0x5A by default.
- R4: After reset every scratch byte reads as 0x00.
- R5: For BUSY_CYCLES clock cycles after a stored scratch write, the slave NACKs its own address. Once the interval has elapsed, it ACKs again.
- R6: An address byte that does not match SLAVE_ADDR (default 0x50) gets a NACK. SDA stays released until the next Start, and no data from that transaction is stored.
- R7: A Stop or Start that arrives before the data byte of a Write Byte is complete aborts the transaction, and the scratch location keeps its old value.
- R8: The slave changes its SDA drive only while SCL is low. It releases SDA after the master's NACK of the read byte.
- R9: While and after reset, SDA is released (sda_oe_o = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that SCL stays low for longer than the synchronizer delay plus one cycle, so that every change of the drive falls inside the low phase. They also assume that no master creates a Start or Stop while the slave is pulling SDA low. The bench master runs every bus phase for six clock cycles and toggles SDA only after SCL has been low for a full phase. It never raises SDA during an ACK or a read data bit, so it stays within both assumptions. Random Read Byte and Write Byte traffic waits out the busy interval after each scratch write. Directed sequences deliberately probe inside that interval and cut transactions short with Stop and repeated Start.

// File: rtl/smb_mem_pkg.sv
package smb_mem_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_WAIT} state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} phase_e;

  function automatic logic [7:0] rom_byte(input int unsigned idx, input logic [7:0] seed);
    logic [31:0] v;
    v = idx * 32'd29 + {24'd0, seed};
    return v[7:0];
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  // SDA edge while SCL held high
  assign start_o    = scl_q & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/smb_busy_timer.sv
module smb_busy_timer #(
  parameter int unsigned CYCLES = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/smb_mem_store.sv
module smb_mem_store
  import smb_mem_pkg::*;
#(
  parameter int unsigned HALF_DEPTH = 128,
  parameter logic [7:0]  ROM_SEED   = 8'h5A
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic                          region_i,
  input  logic [$clog2(HALF_DEPTH)-1:0] idx_i,
  input  logic [7:0]                    wdata_i,
  output logic [7:0]                    rdata_o
);
  logic [7:0] rom_tbl [HALF_DEPTH];
  logic [7:0] scr_q   [HALF_DEPTH];

  for (genvar g = 0; g < HALF_DEPTH; g++) begin : g_rom
    assign rom_tbl[g] = rom_byte(g, ROM_SEED);
  end

  // writes aimed at the ROM half are dropped here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HALF_DEPTH; i++) scr_q[i] <= 8'h00;
    end else if (we_i && region_i) begin
      scr_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = region_i ? scr_q[idx_i] : rom_tbl[idx_i];
endmodule

// File: rtl/smb_split_mem.sv
module smb_split_mem
  import smb_mem_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR  = 7'h50,
  parameter int unsigned BUSY_CYCLES = 2_000_000,
  parameter logic [7:0]  ROM_SEED    = 8'h5A,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int unsigned CMD_W      = 8;
  localparam int unsigned IDX_W      = CMD_W - 1;
  localparam int unsigned HALF_DEPTH = 1 << IDX_W;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit_q;
  logic [7:0] rd_data;

  state_e     state_q;
  phase_e     phase_q;
  logic [2:0] bit_q;
  logic       full_q, rw_q, oe_q;
  logic [7:0] shreg_q, cmd_q, wdata_q;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit_q & cmd_q[7]),
    .busy_o (busy)
  );

  smb_mem_store #(.HALF_DEPTH(HALF_DEPTH), .ROM_SEED(ROM_SEED)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (commit_q),
    .region_i (cmd_q[7]),
    .idx_i    (cmd_q[IDX_W-1:0]),
    .wdata_i  (wdata_q),
    .rdata_o  (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bit_q    <= '0;
      full_q   <= 1'b0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      shreg_q  <= '0;
      cmd_q    <= '0;
      wdata_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (stop_det) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_det) begin
        state_q <= ST_RX;
        phase_q <= PH_ADDR;
        bit_q   <= '0;
        full_q  <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[6:0], sda_s};
              bit_q   <= 3'(bit_q + 3'd1);
              if (bit_q == 3'd7) full_q <= 1'b1;
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (shreg_q[7:1] == SLAVE_ADDR && !busy) begin
                    rw_q    <= shreg_q[0];
                    oe_q    <= 1'b1;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_WAIT;
                  end
                end
                PH_CMD: begin
                  cmd_q   <= shreg_q;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
                default: begin
                  wdata_q <= shreg_q;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              unique case (phase_q)
                PH_ADDR: begin
                  if (rw_q) begin
                    shreg_q <= rd_data;
                    oe_q    <= ~rd_data[7];
                    state_q <= ST_TX;
                  end else begin
                    phase_q <= PH_CMD;
                    state_q <= ST_RX;
                  end
                end
                PH_CMD: begin
                  phase_q <= PH_DATA;
                  state_q <= ST_RX;
                end
                default: begin
                  commit_q <= 1'b1;
                  state_q  <= ST_WAIT;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == 3'd7) begin
                oe_q    <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                shreg_q <= {shreg_q[6:0], 1'b0};
                oe_q    <= ~shreg_q[6];
                bit_q   <= 3'(bit_q + 3'd1);
              end
            end
          end
          ST_MACK: if (scl_fall) state_q <= ST_WAIT;
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/smb_split_mem_chk.sv
module smb_split_mem_chk
  import smb_mem_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   scl_i,
  input logic   sda_oe_o,
  input state_e state_i,
  input phase_e phase_i,
  input logic   stop_i,
  input logic   commit_i,
  input logic   region_i,
  input logic   busy_i
);
  assert_drive_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sda_oe_o) |-> !scl_i);

  assert_wait_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) |-> !sda_oe_o);

  assert_rx_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RX) |-> !sda_oe_o);

  assert_stop_aborts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == ST_IDLE) && !sda_oe_o);

  assert_scratch_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && region_i) |=> busy_i);

  assert_no_ack_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ACK && phase_i == PH_ADDR) |-> !busy_i);

  assert_rom_no_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !region_i && !busy_i) |=> !busy_i);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_released_R9: assert (!sda_oe_o);
  end
endmodule

bind smb_split_mem smb_split_mem_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .state_i  (state_q),
  .phase_i  (phase_q),
  .stop_i   (stop_det),
  .commit_i (commit_q),
  .region_i (cmd_q[7]),
  .busy_i   (busy)
);

// File: tb/tb_smb_split_mem.sv
`timescale 1ns/1ps
module tb_smb_split_mem;
  localparam int Q    = 6;
  localparam int BUSY = 1500;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_bus, sda_oe;

  int n_chk = 0, n_err = 0, viol = 0, oe_hits = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_scr [128];

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  smb_split_mem #(.SLAVE_ADDR(DEV), .BUSY_CYCLES(BUSY)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe)
  );

  // R8 monitor: drive changes only with SCL low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    if (mon_on && sda_oe) oe_hits++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] rom_exp(input int i);
    return 8'((i * 29 + 'h5A) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; idle(Q); scl = 1'b1; idle(Q); m_low = 1'b1; idle(Q); scl = 1'b0; idle(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; idle(Q); scl = 1'b1; idle(Q); m_low = 1'b0; idle(Q);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; idle(Q); scl = 1'b1; idle(2 * Q); scl = 1'b0; idle(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; idle(Q); scl = 1'b1; idle(Q); b = sda_bus; idle(Q); scl = 1'b0; idle(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic write_byte(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output bit a1, output bit a2, output bit a3);
    a2 = 1'b0; a3 = 1'b0;
    bus_start();
    send_byte({a, 1'b0}, a1);
    if (a1) begin
      send_byte(c, a2);
      send_byte(d, a3);
    end
    bus_stop();
  endtask

  task automatic read_byte(input logic [6:0] a, input logic [7:0] c,
                           output bit ok, output logic [7:0] d);
    bit k;
    logic b;
    d = 8'h00;
    bus_start();
    send_byte({a, 1'b0}, k);
    ok = k;
    if (k) begin
      send_byte(c, k);
      bus_start();
      send_byte({a, 1'b1}, k);
      ok = ok & k;
      for (int i = 7; i >= 0; i--) begin
        recv_bit(b);
        d[i] = b;
      end
      send_bit(1'b1);
      check(sda_oe == 1'b0, "R8 released after master NACK", sda_oe, 0);
    end
    bus_stop();
  endtask

  task automatic probe(input logic [6:0] a, output bit ack);
    bus_start();
    send_byte({a, 1'b0}, ack);
    bus_stop();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
    $finish;
  end

  initial begin
    bit a1, a2, a3, ok;
    logic [7:0] d;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 128; i++) exp_scr[i] = 8'h00;

    idle(4);
    check(sda_oe == 1'b0, "R9 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    idle(10);
    check(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);

    // R4 scratch reset values
    read_byte(DEV, 8'h80, ok, d);
    check(ok && d == 8'h00, "R4 scratch 0x80", d, 0);
    read_byte(DEV, 8'hFF, ok, d);
    check(ok && d == 8'h00, "R4 scratch 0xFF", d, 0);

    // R3 ROM boundaries
    read_byte(DEV, 8'h00, ok, d);
    check(ok && d == rom_exp(0), "R3 rom 0x00", d, rom_exp(0));
    read_byte(DEV, 8'h7F, ok, d);
    check(ok && d == rom_exp(127), "R3 rom 0x7F", d, rom_exp(127));

    // R2 write to protected half
    write_byte(DEV, 8'h10, 8'hEE, a1, a2, a3);
    check(a1 && a2 && a3, "R2 three ACKs on ROM write", {a1, a2, a3}, 7);
    read_byte(DEV, 8'h10, ok, d);
    check(ok, "R2 no busy after ROM write", ok, 1);
    check(d == rom_exp(16), "R2 ROM unchanged", d, rom_exp(16));

    // R1 / R5 scratch write and busy window
    write_byte(DEV, 8'h83, 8'h3C, a1, a2, a3);
    check(a1 && a2 && a3, "R1 three ACKs on scratch write", {a1, a2, a3}, 7);
    exp_scr[3] = 8'h3C;
    probe(DEV, ok);
    check(!ok, "R5 NACK during busy", ok, 0);
    idle(BUSY + 50);
    read_byte(DEV, 8'h83, ok, d);
    check(ok, "R5 ACK after busy", ok, 1);
    check(d == 8'h3C, "R1 scratch readback", d, 8'h3C);

    // R6 foreign address
    bus_start();
    send_byte({7'h51, 1'b0}, ok);
    check(!ok, "R6 foreign address NACK", ok, 0);
    oe_hits = 0; mon_on = 1'b1;
    send_byte(8'h00, ok);
    send_byte(8'h00, ok);
    mon_on = 1'b0;
    bus_stop();
    check(oe_hits == 0, "R6 SDA released until Start", oe_hits, 0);
    write_byte(7'h51, 8'h84, 8'h77, a1, a2, a3);
    read_byte(DEV, 8'h84, ok, d);
    check(ok && d == 8'h00, "R6 no store on foreign address", d, 0);

    // R7 aborts
    bus_start();
    send_byte({DEV, 1'b0}, ok);
    send_byte(8'h85, ok);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    read_byte(DEV, 8'h85, ok, d);
    check(ok, "R7 no busy after aborted write", ok, 1);
    check(d == 8'h00, "R7 Stop abort keeps old value", d, 0);
    bus_start();
    send_byte({DEV, 1'b0}, ok);
    send_byte(8'h86, ok);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    send_byte({DEV, 1'b1}, ok);
    d = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(1'b1);
    bus_stop();
    check(ok && d == 8'h00, "R7 Start abort keeps old value", d, 0);

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] c, v;
      c = 8'($urandom);
      v = 8'($urandom);
      if ($urandom % 2) begin
        write_byte(DEV, c, v, a1, a2, a3);
        check(a1 && a2 && a3, c[7] ? "R1 random write ACKs" : "R2 random write ACKs",
              {a1, a2, a3}, 7);
        if (c[7]) begin
          exp_scr[c[6:0]] = v;
          idle(BUSY + 50);
        end
      end else begin
        read_byte(DEV, c, ok, d);
        check(ok && d == (c[7] ? exp_scr[c[6:0]] : rom_exp(int'(c[6:0]))),
              "R3 random read", d, c[7] ? exp_scr[c[6:0]] : rom_exp(int'(c[6:0])));
      end
    end

    check(viol == 0, "R8 drive changes only with SCL low", viol, 0);
    summary();
    $finish;
  end
endmodule